// File: doc/BRIEF.md
# Transmit Line-Enable Sequencer

This block runs one frame transmission on a shared half-duplex line with collision avoidance. It owns the line-driver enable and measures every interval in bit times, counted as pulses on a bit-rate tick. It feeds data bytes to an external serial framer, which adds the opening and closing flags and the CRC and shifts the bits out. A start request opens the sequence. The drivers send a short sync pulse and then fall silent for a few bit times, long enough for every listener to see an edge and then lose clock. The drivers then come on for the frame. The sequencer waits while the framer sends its leading flags, and then passes the bytes across one at a time on the framer's buffer-empty handshake. The address bytes at the front of the frame travel as ordinary data.

Once the first byte is written, the block tells the framer to mark the line when idle, so that the frame closes with marking rather than more flags. After the final byte the drivers stay on for a fixed trailing hold. This hold covers the byte still in the shifter, the CRC, the closing flag and the marking. The drivers are then released and done pulses. If the framer stops draining bytes for too long, the sequencer drops the drivers and holds an error flag until the next start.

Top module: `txline_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, all outputs (drv_en_o, wr_o, mark_idle_o, done_o, err_o) are low.
- R2: A start_i sampled high while the block is idle raises drv_en_o on the next clock. drv_en_o then stays high for exactly SYNC_CLKS clock cycles (the sync pulse) and falls.
- R3: After the sync pulse, drv_en_o stays low until the clock edge that samples the QUIET_BITS-th bit tick (default 3: one bit time for a transition plus two for loss of clock). It rises on that edge.
- R4: After the drivers are enabled, the first byte is written (wr_o high for one cycle, wr_data_o equal to byte_i) on the edge that samples the LEAD_BITS-th tick (default 16, two flags), whatever the buffer-empty flag shows.
- R5: Every later byte is written only on an edge where tx_empty_i is sampled high, and never in the cycle that follows a write. Bytes go out in input order with their values unchanged. The write that carries last_i high is the final write of the frame.
- R6: mark_idle_o pulses high for exactly one cycle per frame, in the cycle after the first byte's write cycle.
- R7: After the final write, drv_en_o stays high until the edge that samples the trailing-hold count of ticks, counting the final write's own cycle. It then falls, and done_o is high for exactly that one cycle.
- R8: The trailing-hold count is TRAIL_BITS limited to the range 44..50 (a setting of 53 gives 50).
- R9: start_i has no effect while a frame is in progress (from the sync pulse to the release of the drivers). It starts no new sync pulse and does not alter the sequence.
- R10: If tx_empty_i is sampled low on STALL_BITS+1 ticks while a byte is waiting, with no write in between, drv_en_o falls and err_o rises on the same edge and done_o stays low. err_o stays high until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to transmit one frame |
| byte_i | input | DW | Next frame byte, consumed on each write |
| last_i | input | 1 | Marks byte_i as the final byte of the frame |
| tx_empty_i | input | 1 | Framer transmit buffer empty |
| bit_tick_i | input | 1 | One-cycle pulse per bit time |
| drv_en_o | output | 1 | Line-driver enable |
| wr_o | output | 1 | Byte write strobe to the framer |
| wr_data_o | output | DW | Byte presented with the write strobe |
| mark_idle_o | output | 1 | One-cycle command: mark the line when idle |
| done_o | output | 1 | One-cycle pulse when the drivers are released |
| err_o | output | 1 | Framer stall abort flag |

## Verification
The bench builds the block with SYNC_CLKS=3 and keeps the default silence (3 ticks), lead-in (16 ticks) and stall limit (32 ticks). It sets TRAIL_BITS to 53, so the trailing hold must come out clamped to 50. The bit tick arrives every fourth clock and the modelled framer takes 32 clocks per byte, so frames of five bytes and one byte both fit in a short run, and real back-pressure is exercised. A jam control holds the framer's empty flag low, which brings the 33-tick stall abort within reach. A start pulse issued mid-frame shows that a busy request is ignored.

// File: rtl/txline_pkg.sv
package txline_pkg;

  localparam int TRAIL_MIN = 44;
  localparam int TRAIL_MAX = 50;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_QUIET,
    ST_LEAD,
    ST_SEND,
    ST_GUARD,
    ST_TRAIL
  } seq_state_t;

  function automatic int clamp_trail(input int v);
    if (v < TRAIL_MIN) return TRAIL_MIN;
    if (v > TRAIL_MAX) return TRAIL_MAX;
    return v;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/txline_bitcnt.sv
// Loadable down counter of enable pulses; flags the pulse that reaches one.
module txline_bitcnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         last_tick
);
  logic [W-1:0] cnt;

  assign last_tick = tick && (cnt == W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick && (cnt != '0)) begin
      cnt <= cnt - W'(1);
    end
  end
endmodule

// File: rtl/txline_stallmon.sv
// Counts bit ticks on which the framer buffer is still full.
module txline_stallmon #(
  parameter int LIMIT = 32,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic watch,
  input  logic tick,
  input  logic empty,
  output logic over
);
  logic [W-1:0] cnt;
  logic         hit;

  assign hit  = watch && tick && !empty;
  assign over = hit && (cnt == W'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (hit && (cnt != W'(LIMIT))) begin
      cnt <= cnt + W'(1);
    end
  end
endmodule

// File: rtl/txline_seq.sv
module txline_seq
  import txline_pkg::*;
#(
  parameter int DW         = 8,
  parameter int SYNC_CLKS  = 4,
  parameter int QUIET_BITS = 3,
  parameter int LEAD_BITS  = 16,
  parameter int TRAIL_BITS = 48,
  parameter int STALL_BITS = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [DW-1:0] byte_i,
  input  logic          last_i,
  input  logic          tx_empty_i,
  input  logic          bit_tick_i,
  output logic          drv_en_o,
  output logic          wr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          mark_idle_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int TRAIL_EFF = clamp_trail(TRAIL_BITS);
  localparam int MAXB      = max3(QUIET_BITS, LEAD_BITS, TRAIL_EFF);
  localparam int CW        = $clog2(MAXB + 1);
  localparam int SW        = $clog2(SYNC_CLKS + 1);

  seq_state_t st;
  logic          ld_sync, sync_last;
  logic          ld_bit, bit_last;
  logic [CW-1:0] ld_val;
  logic          take, stall_over;
  logic          first_q;

  // Sync pulse width in clocks: counter advances every cycle.
  txline_bitcnt #(.W(SW)) sync_cnt_i (
    .clk      (clk),
    .rst      (rst),
    .load     (ld_sync),
    .load_val (SW'(SYNC_CLKS)),
    .tick     (1'b1),
    .last_tick(sync_last)
  );

  // Silence, lead-in and trailing hold in bit times.
  txline_bitcnt #(.W(CW)) bit_cnt_i (
    .clk      (clk),
    .rst      (rst),
    .load     (ld_bit),
    .load_val (ld_val),
    .tick     (bit_tick_i),
    .last_tick(bit_last)
  );

  txline_stallmon #(.LIMIT(STALL_BITS)) stall_i (
    .clk  (clk),
    .rst  (rst),
    .clear(take),
    .watch(st == ST_SEND),
    .tick (bit_tick_i),
    .empty(tx_empty_i),
    .over (stall_over)
  );

  always_comb begin
    ld_sync = (st == ST_IDLE) && start_i;
    ld_bit  = 1'b0;
    ld_val  = '0;
    take    = 1'b0;
    case (st)
      ST_SYNC:  if (sync_last) begin ld_bit = 1'b1; ld_val = CW'(QUIET_BITS); end
      ST_QUIET: if (bit_last)  begin ld_bit = 1'b1; ld_val = CW'(LEAD_BITS);  end
      ST_LEAD:  take = bit_last;
      ST_SEND:  take = tx_empty_i;
      default:  ;
    endcase
    if (take && last_i) begin
      ld_bit = 1'b1;
      ld_val = CW'(TRAIL_EFF);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      drv_en_o    <= 1'b0;
      wr_o        <= 1'b0;
      wr_data_o   <= '0;
      mark_idle_o <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      first_q     <= 1'b0;
    end else begin
      wr_o        <= 1'b0;
      done_o      <= 1'b0;
      mark_idle_o <= first_q;
      first_q     <= 1'b0;
      case (st)
        ST_IDLE: if (start_i) begin
          st       <= ST_SYNC;
          drv_en_o <= 1'b1;
          err_o    <= 1'b0;
        end
        ST_SYNC: if (sync_last) begin
          st       <= ST_QUIET;
          drv_en_o <= 1'b0;
        end
        ST_QUIET: if (bit_last) begin
          st       <= ST_LEAD;
          drv_en_o <= 1'b1;
        end
        ST_LEAD: if (bit_last) first_q <= 1'b1;
        ST_SEND: if (stall_over) begin
          st       <= ST_IDLE;
          drv_en_o <= 1'b0;
          err_o    <= 1'b1;
        end
        ST_GUARD: st <= ST_SEND;
        ST_TRAIL: if (bit_last) begin
          st       <= ST_IDLE;
          drv_en_o <= 1'b0;
          done_o   <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
      if (take) begin
        wr_o      <= 1'b1;
        wr_data_o <= byte_i;
        st        <= last_i ? ST_TRAIL : ST_GUARD;
      end
    end
  end
endmodule

// File: rtl/txline_seq_chk.sv
module txline_seq_chk (
  input logic clk,
  input logic rst,
  input logic drv_en_o,
  input logic wr_o,
  input logic mark_idle_o,
  input logic done_o,
  input logic err_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!drv_en_o && !wr_o && !mark_idle_o && !done_o && !err_o));

  // R5
  wr_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    wr_o |=> !wr_o);

  // R5
  wr_driven_chk: assert property (@(posedge clk) disable iff (rst)
    wr_o |-> drv_en_o);

  // R6
  mark_single_chk: assert property (@(posedge clk) disable iff (rst)
    mark_idle_o |=> !mark_idle_o);

  // R6
  mark_driven_chk: assert property (@(posedge clk) disable iff (rst)
    mark_idle_o |-> drv_en_o);

  // R7
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!drv_en_o && $past(drv_en_o)));

  // R10
  err_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> (!drv_en_o && !done_o));
endmodule

bind txline_seq txline_seq_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .drv_en_o   (drv_en_o),
  .wr_o       (wr_o),
  .mark_idle_o(mark_idle_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/txline_seq_tb_top.sv
`timescale 1ns/1ps
module txline_seq_tb_top;
  localparam int SYNC  = 3;
  localparam int QUIET = 3;
  localparam int LEAD  = 16;
  localparam int TRSET = 53;
  localparam int TREXP = (TRSET > 50) ? 50 : ((TRSET < 44) ? 44 : TRSET);
  localparam int STALL = 32;
  localparam int BYTE_CLKS = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic tick = 1'b0;
  logic empty = 1'b1;
  logic jam = 1'b0;
  logic [7:0] byte_in;
  logic last_in;
  logic drv, wr, mark, done, err;
  logic [7:0] wdata;

  logic [7:0] frame [16];
  int len = 0;
  int idx = 0;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  assign byte_in = (idx < len) ? frame[idx] : 8'h00;
  assign last_in = (idx == len - 1);

  txline_seq #(.DW(8), .SYNC_CLKS(SYNC), .QUIET_BITS(QUIET), .LEAD_BITS(LEAD),
               .TRAIL_BITS(TRSET), .STALL_BITS(STALL)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .byte_i(byte_in), .last_i(last_in),
    .tx_empty_i(empty), .bit_tick_i(tick), .drv_en_o(drv), .wr_o(wr),
    .wr_data_o(wdata), .mark_idle_o(mark), .done_o(done), .err_o(err));

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Bit tick every fourth clock, byte source, framer model.
  int tcnt = 0, fcnt = 0;
  always @(negedge clk) begin
    tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
    tick <= (tcnt == 2);
    if (!rst && wr) idx <= idx + 1;
    if (rst) begin
      empty <= 1'b1; fcnt <= 0;
    end else if (wr) begin
      empty <= 1'b0; fcnt <= BYTE_CLKS;
    end else if (fcnt > 0) begin
      fcnt <= fcnt - 1;
    end else if (!jam) begin
      empty <= 1'b1;
    end
  end

  // Behavioural reference: phase number plus tick counters.
  int ph = 0, n = 0, stl = 0;
  bit mpend = 0;
  logic e_drv = 0, e_wr = 0, e_mark = 0, e_done = 0, e_err = 0;
  logic [7:0] e_data = 0;
  always @(posedge clk) begin
    if (rst) begin
      ph = 0; n = 0; stl = 0; mpend = 0;
      e_drv = 0; e_wr = 0; e_mark = 0; e_done = 0; e_err = 0;
    end else begin
      bit put;
      put = 0;
      e_wr = 0; e_done = 0; e_mark = mpend; mpend = 0;
      case (ph)
        0: if (start) begin ph = 1; n = 0; e_drv = 1; e_err = 0; end
        1: begin n++; if (n == SYNC) begin ph = 2; n = 0; e_drv = 0; end end
        2: if (tick) begin n++; if (n == QUIET) begin ph = 3; n = 0; e_drv = 1; end end
        3: if (tick) begin n++; if (n == LEAD) begin put = 1; mpend = 1; end end
        4: ph = 5;
        5: if (empty) put = 1;
           else if (tick) begin
             stl++;
             if (stl > STALL) begin ph = 0; e_drv = 0; e_err = 1; end
           end
        6: if (tick) begin n++; if (n == TREXP) begin ph = 0; e_drv = 0; e_done = 1; end end
        default: ph = 0;
      endcase
      if (put) begin
        e_wr = 1; e_data = byte_in; stl = 0; n = 0;
        ph = last_in ? 6 : 4;
      end
    end
  end

  function automatic string ph_tag(input int p);
    case (p)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4, 5: return "R5";
      6: return "R7";
      default: return "R9";
    endcase
  endfunction

  // Cycle-by-cycle comparison.
  always @(negedge clk) if (!rst) begin
    chk(drv == e_drv, ph_tag(ph), "drv_en", drv, e_drv);
    chk(wr == e_wr, "R5", "wr", wr, e_wr);
    if (e_wr) chk(wdata == e_data, "R5", "wr_data", wdata, e_data);
    chk(mark == e_mark, "R6", "mark_idle", mark, e_mark);
    chk(done == e_done, "R7", "done", done, e_done);
    chk(err == e_err, "R10", "err", err, e_err);
  end

  // Interval monitor (runs after negedge updates so tick pairs with outputs).
  int mph = 0, sync_hi = 0, quiet_t = 0, lead_t = 0, trail_t = 0;
  int ncap = 0, mk = 0, dn = 0, rises = 0;
  logic [7:0] cap [16];
  logic drv_q = 0;
  always begin
    @(negedge clk); #1;
    if (!rst) begin
      if (drv && !drv_q) rises++;
      drv_q = drv;
      if (mark) mk++;
      if (done) dn++;
      case (mph)
        0: if (drv) begin mph = 1; sync_hi = 1; end
        1: if (drv) sync_hi++; else begin mph = 2; quiet_t = tick; end
        2: if (!drv) quiet_t += tick; else begin mph = 3; lead_t = tick; end
        3, 4: begin
          if (!drv) mph = 0;
          else if (wr) begin
            cap[ncap] = wdata; ncap++;
            if (ncap == len) begin mph = 5; trail_t = tick; end
            else mph = 4;
          end else if (mph == 3) lead_t += tick;
        end
        5: if (drv) trail_t += tick; else mph = 0;
        default: mph = 0;
      endcase
    end
  end

  task automatic load_frame(input int l, input int seed);
    for (int i = 0; i < l; i++) frame[i] = 8'(seed * 37 + i * 11 + 5);
    len = l; idx = 0;
    ncap = 0; mk = 0; dn = 0; rises = 0; mph = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done || err) break;
    end
    repeat (3) @(negedge clk);
    #2;
  endtask

  task automatic check_frame(input int l);
    chk(sync_hi == SYNC, "R2", "sync width", sync_hi, SYNC);
    chk(quiet_t == QUIET, "R3", "silence ticks", quiet_t, QUIET);
    chk(lead_t == LEAD, "R4", "lead ticks", lead_t, LEAD);
    chk(ncap == l, "R5", "bytes written", ncap, l);
    for (int i = 0; i < l; i++)
      chk(cap[i] == frame[i], "R5", "byte order", cap[i], frame[i]);
    chk(mk == 1, "R6", "mark pulses", mk, 1);
    chk(trail_t == TREXP, "R8", "trail ticks clamped", trail_t, TREXP);
    chk(dn == 1, "R7", "done pulses", dn, 1);
    chk(err == 0, "R10", "err clear", err, 0);
  endtask

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: outputs low under reset
    chk({drv, wr, mark, done, err} == 5'b0, "R1", "reset outputs", {drv, wr, mark, done, err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({drv, wr, mark, done, err} == 5'b0, "R1", "after reset", {drv, wr, mark, done, err}, 0);

    // Five-byte frame with start pulses mid-frame (R9)
    load_frame(5, 1);
    pulse_start();
    repeat (60) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (150) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_end();
    check_frame(5);
    chk(rises == 2, "R9", "driver rises per frame", rises, 2);

    // Single-byte frame: first byte is the last
    load_frame(1, 2);
    pulse_start();
    wait_end();
    check_frame(1);

    // Stalled framer (R10)
    load_frame(4, 3);
    jam = 1'b1;
    pulse_start();
    wait_end();
    chk(err == 1, "R10", "err raised", err, 1);
    chk(drv == 0, "R10", "drivers off", drv, 0);
    chk(dn == 0, "R10", "no done on abort", dn, 0);
    chk(ncap == 1, "R10", "bytes before stall", ncap, 1);
    repeat (20) @(negedge clk);
    chk(err == 1, "R10", "err held", err, 1);
    jam = 1'b0;
    repeat (40) @(negedge clk);

    // Recovery frame clears err
    load_frame(3, 4);
    pulse_start();
    #2;
    chk(err == 0, "R10", "err cleared by start", err, 0);
    wait_end();
    check_frame(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule